// File: doc/BRIEF.md
# Pipelined Shift and Rotate Unit

This block is the shift and rotate slice of a small processor's execution stage. A 16-bit operand, a 4-bit shift count and a 3-bit operation code enter together with a valid flag. Exactly one clock later the block presents the 16-bit result and a matching valid flag. The next stage feeds that result into the ALU's shared result multiplexer.

A single logarithmic network of four mux stages serves all five operations. Left-going operations reverse the operand before the network and reverse the result after it, so the network itself only ever moves bits toward the low end. Right shifts and rotates use the same network. A register splits the network after its first two stages, so each side holds only two levels of muxing. Because of that register the unit accepts one new operation on every clock.

Top module: `shift_rotate_unit`

## Requirements
- R1: `validOut` equals the `validIn` presented one clock earlier when reset was low at that edge.
- R2: While `rst` is high at a rising edge, `validOut` is low after that edge.
- R3: Operation code 0 (shift left) moves the operand up by `amount` bit positions and fills the vacated low bits with zero.
- R4: Operation code 1 (logical shift right) moves the operand down by `amount` positions and fills the vacated high bits with zero.
- R5: Operation code 2 (arithmetic shift right) moves the operand down by `amount` positions and fills the vacated high bits with the operand's bit 15.
- R6: Operation code 3 (rotate left) moves the operand up by `amount` positions. Bits leaving bit 15 re-enter at bit 0, so no bit is lost.
- R7: Operation code 4 (rotate right) moves the operand down by `amount` positions. Bits leaving bit 0 re-enter at bit 15.
- R8: An `amount` of 0 returns the operand unchanged for every operation code from 0 to 4.
- R9: Operation codes 5, 6 and 7 produce a result of zero.
- R10: A new operation may enter on every clock. Each result depends only on the inputs of its own cycle, not on those of the cycle before or after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the output valid |
| validIn | input | 1 | The operand, amount and code in this cycle are to be processed |
| opSel | input | 3 | Operation code: 0 shl, 1 shr, 2 sar, 3 rol, 4 ror, others give zero |
| operand | input | 16 | Value to be shifted or rotated |
| amount | input | 4 | Shift or rotate count, 0 to 15 |
| validOut | output | 1 | The result presented this cycle is valid |
| result | output | 16 | Shift or rotate result, one clock after its inputs |

## Verification
Two things can fall in the same cycle. The pipeline register can be handing out one result while the front half of the network already takes the next operation. Reset can also arrive in a cycle where `validIn` is high. The bench provokes the first case by sweeping every operation code against every amount with no idle cycles between vectors, so each result must match its own inputs and not its neighbour's. It provokes the second case by asserting reset in the middle of a valid stream. There it expects `validOut` low on the following cycle and the stream to resume cleanly afterwards.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4
  } shiftOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic leftDir;   // reverse bits around the network
    logic rotate;    // wrap bits instead of filling
    logic arith;     // fill with sign bit
    logic kill;      // force result to zero
  } shiftCtrl_t;

endpackage

// File: rtl/shift_rotate_ctrl.sv
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
(
  input  logic [2:0]  opSel,
  output shiftCtrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (opSel)
      OP_SHL: ctrl.leftDir = 1'b1;
      OP_SHR: ;
      OP_SAR: ctrl.arith = 1'b1;
      OP_ROL: begin
        ctrl.leftDir = 1'b1;
        ctrl.rotate  = 1'b1;
      end
      OP_ROR: ctrl.rotate = 1'b1;
      default: ctrl.kill = 1'b1;
    endcase
  end

endmodule

// File: rtl/shift_rotate_datapath.sv
module shift_rotate_datapath
  import shift_rotate_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SPLIT = 2,                 // stages before the register, 1..AMT_W-1
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              validIn,
  input  shiftCtrl_t        ctrl,
  input  logic [WIDTH-1:0]  operand,
  input  logic [AMT_W-1:0]  amount,
  output logic              validOut,
  output logic [WIDTH-1:0]  result
);

  function automatic logic [WIDTH-1:0] bitReverse(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic [WIDTH-1:0] orientIn;
  logic             fillIn;
  logic [WIDTH-1:0] stageOut [AMT_W];

  // pipeline state
  logic [WIDTH-1:0]       heldVal;
  logic [AMT_W-SPLIT-1:0] heldAmt;
  logic                   heldRotate;
  logic                   heldFill;
  logic                   heldLeft;
  logic                   heldKill;
  logic                   validQ;

  assign orientIn = ctrl.leftDir ? bitReverse(operand) : operand;
  assign fillIn   = ctrl.arith & operand[WIDTH-1];

  for (genvar k = 0; k < AMT_W; k++) begin : gStage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] srcV;
    logic             useBit;
    logic             rot;
    logic             fill;

    if (k == 0) begin : gFirst
      assign srcV = orientIn;
    end else if (k == SPLIT) begin : gAfterReg
      assign srcV = heldVal;
    end else begin : gChain
      assign srcV = stageOut[k-1];
    end

    if (k < SPLIT) begin : gFront
      assign useBit = amount[k];
      assign rot    = ctrl.rotate;
      assign fill   = fillIn;
    end else begin : gBack
      assign useBit = heldAmt[k-SPLIT];
      assign rot    = heldRotate;
      assign fill   = heldFill;
    end

    assign stageOut[k] = !useBit ? srcV
                       : rot     ? {srcV[S-1:0], srcV[WIDTH-1:S]}
                                 : {{S{fill}}, srcV[WIDTH-1:S]};
  end

  always_ff @(posedge clk) begin
    heldVal    <= stageOut[SPLIT-1];
    heldAmt    <= amount[AMT_W-1:SPLIT];
    heldRotate <= ctrl.rotate;
    heldFill   <= fillIn;
    heldLeft   <= ctrl.leftDir;
    heldKill   <= ctrl.kill;
    if (rst) validQ <= 1'b0;
    else     validQ <= validIn;
  end

  assign validOut = validQ;
  assign result   = heldKill ? '0
                  : heldLeft ? bitReverse(stageOut[AMT_W-1])
                             : stageOut[AMT_W-1];

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SPLIT = 2,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              validIn,
  input  logic [2:0]        opSel,
  input  logic [WIDTH-1:0]  operand,
  input  logic [AMT_W-1:0]  amount,
  output logic              validOut,
  output logic [WIDTH-1:0]  result
);

  shiftCtrl_t ctrlStrobes;

  shift_rotate_ctrl uCtrl (
    .opSel (opSel),
    .ctrl  (ctrlStrobes)
  );

  shift_rotate_datapath #(.WIDTH(WIDTH), .SPLIT(SPLIT)) uPath (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .ctrl     (ctrlStrobes),
    .operand  (operand),
    .amount   (amount),
    .validOut (validOut),
    .result   (result)
  );

endmodule

// File: rtl/shift_rotate_chk.sv
module shift_rotate_chk #(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             validIn,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] operand,
  input logic [AMT_W-1:0] amount,
  input logic             validOut,
  input logic [WIDTH-1:0] result
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);

  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);

  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> !validOut);

  assert_shl_zero_lsb_R3: assert property (@(posedge clk) disable iff (rst)
    (validIn && opSel == 3'd0 && amount != '0) |=> (result[0] == 1'b0));

  assert_shr_zero_msb_R4: assert property (@(posedge clk) disable iff (rst)
    (validIn && opSel == 3'd1 && amount != '0) |=> (result[WIDTH-1] == 1'b0));

  assert_sar_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (validIn && opSel == 3'd2) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));

  // R6 and R7: rotation keeps every bit
  assert_rotate_keeps_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (validIn && (opSel == 3'd3 || opSel == 3'd4)) |=>
      ($countones(result) == $countones($past(operand))));

  assert_zero_amount_R8: assert property (@(posedge clk) disable iff (rst)
    (validIn && opSel <= 3'd4 && amount == '0) |=> (result == $past(operand)));

  assert_unused_code_R9: assert property (@(posedge clk) disable iff (rst)
    (validIn && opSel > 3'd4) |=> (result == '0));

endmodule

bind shift_rotate_unit shift_rotate_chk #(.WIDTH(WIDTH)) uChk (.*);

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        validIn;
  logic [2:0]  opSel;
  logic [15:0] operand;
  logic [3:0]  amount;
  logic        validOut;
  logic [15:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values for the cycle in flight
  bit          pendValid;
  logic [15:0] pendResult;
  string       pendTag;

  always #10 clk = ~clk;   // 50 MHz

  shift_rotate_unit dut (
    .clk(clk), .rst(rst), .validIn(validIn), .opSel(opSel),
    .operand(operand), .amount(amount), .validOut(validOut), .result(result)
  );

  function automatic logic [15:0] refModel(int op, logic [15:0] x, int n);
    logic [15:0] v = x;
    if (op > 4) return 16'h0000;
    for (int i = 0; i < n; i++) begin
      case (op)
        0: v = {v[14:0], 1'b0};
        1: v = {1'b0, v[15:1]};
        2: v = {v[15], v[15:1]};
        3: v = {v[14:0], v[15]};
        default: v = {v[0], v[15:1]};
      endcase
    end
    return v;
  endfunction

  function automatic string tagFor(int op, int n);
    if (op > 4) return "R9";
    if (n == 0) return "R8";
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  // called at negedge: compare previous edge's result, then drive next inputs
  task automatic stepCycle(bit r, bit v, int op, logic [15:0] x, int n);
    checks++;
    if (validOut !== pendValid) begin
      fails++;
      $display("FAIL R1/R2 validOut actual=%0b expected=%0b", validOut, pendValid);
    end
    if (pendValid) begin
      checks++;
      if (result !== pendResult) begin
        fails++;
        $display("FAIL %s/R10 result actual=%h expected=%h", pendTag, result, pendResult);
      end
    end
    rst     = r;
    validIn = v;
    opSel   = 3'(op);
    operand = x;
    amount  = 4'(n);
    pendValid  = v && !r;
    pendResult = refModel(op, x, n);
    pendTag    = tagFor(op, n);
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] pats [4] = '{16'h8001, 16'h7FFE, 16'hA5C3, 16'h1234};
    rst = 1'b1; validIn = 1'b0; opSel = '0; operand = '0; amount = '0;
    pendValid = 0; pendResult = '0; pendTag = "R2";
    @(negedge clk);
    @(negedge clk);
    // R2: reset state
    stepCycle(1, 0, 0, 16'h0, 0);
    // R10: back-to-back sweep of every code and amount
    foreach (pats[p]) begin
      for (int op = 0; op < 8; op++) begin
        for (int n = 0; n < 16; n++) stepCycle(0, 1, op, pats[p], n);
      end
    end
    // R1: idle gaps interleaved with valid vectors
    for (int i = 0; i < 16; i++) begin
      stepCycle(0, i[0], i % 5, 16'hF00D ^ 16'(i * 16'h1111), i);
    end
    // R2: reset arriving together with a valid input
    stepCycle(0, 1, 2, 16'h8421, 3);
    stepCycle(1, 1, 3, 16'h1357, 5);
    stepCycle(0, 1, 4, 16'h2468, 7);
    stepCycle(0, 1, 0, 16'hFFFF, 15);
    stepCycle(0, 0, 0, 16'h0, 0);
    stepCycle(0, 0, 0, 16'h0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule